// File: doc/BRIEF.md
# Pulse-Width Coded Serial Receiver

This block recovers a bit stream from one self-clocked input line that carries no separate clock. The line rests high. Every symbol opens with a falling edge, and the length of the low phase that follows gives the bit. In a 4 µs symbol (250 kbit/s nominal), a zero stays low for about three quarters of the symbol and a one for about one quarter.

The receiver passes the asynchronous line through a two-flop synchroniser and finds each falling edge. Each edge starts a delay timer of `SAMPLE_DLY` system clocks, which is half a symbol. The timer acts like a retriggerable monostable. When it expires, the line level is taken as the bit. Bits are packed first-received-first into `WORD_W`-bit words and offered on a valid/ready output.

A frame closes when the line has been quiet for `IDLE_LIM` clocks after the last sample. At that point the remaining bits are flushed in one final word marked as last, together with its count of valid bits. Two error conditions are flagged. An edge that arrives before the sample point is a framing error. A word that is produced while the previous one is still waiting is an overrun.

Top module: `pwc_rx`

## Requirements
- R1: After reset, `out_valid`, `overrun` and `frame_err` are all 0.
- R2: The line idles high, and a line held high produces no output word.
- R3: A symbol starts at a falling edge of `line_in`. The line is sampled `SAMPLE_DLY` clocks after that edge: low decodes as 0 and high decodes as 1. A low phase longer than `SAMPLE_DLY` is therefore a zero, and a shorter one is a one.
- R4: Decoded bits fill words first bit into bit `WORD_W-1`, the most significant end. A word that holds `WORD_W` bits is emitted with `out_count = WORD_W` and `out_last = 0`.
- R5: When no falling edge arrives for `IDLE_LIM` clocks after the last sample, one word with `out_last = 1` is emitted. Its `out_count` is the number of leftover bits (0 to `WORD_W-1`). Those bits are left-aligned from the most significant end and the unused bits are 0. A frame whose length is a multiple of `WORD_W` ends with an empty word, which has count 0 and data 0.
- R6: Once `out_valid` is high, it and the word stay unchanged until a cycle with `out_ready` high, unless a newer word replaces it (R7).
- R7: If a word is produced while the previous one is still pending, the newer word replaces it and `overrun` goes to 1. `overrun` returns to 0 after the next accepted transfer.
- R8: A falling edge that arrives while the delay timer is running gives a one-cycle `frame_err` pulse. It discards the interrupted symbol and restarts the timer from the new edge.
- R9: Low-phase lengths may jitter by a few clocks, and pauses between symbols may be shorter than `IDLE_LIM`. In both cases the frame stays open and every bit is decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Asynchronous pulse-width coded line, idle high |
| out_ready | input | 1 | Consumer takes the current word |
| out_valid | output | 1 | A word is offered |
| out_data | output | WORD_W | Packed bits, first bit in the MSB |
| out_count | output | $clog2(WORD_W+1) | Number of valid bits in the word |
| out_last | output | 1 | Final word of a frame |
| overrun | output | 1 | A pending word was overwritten |
| frame_err | output | 1 | One-cycle pulse when an edge came before the sample point |

## Verification
Frames of exactly one word are the first corner case. A receiver that forgot the empty terminator would close such frames with no last word. A receiver that flushed a full word as last would give a count of 8 instead of 0 on it.

Short frames of 1 to 7 bits check left alignment. A design that right-aligns the leftover bits would return, for example, 0x05 instead of 0xA0 for the bits 1,0,1.

A glitch edge before the sample point checks that the interrupted symbol is dropped and the timer restarts. A receiver without that restart would decode an extra bit.

A long stall of the consumer checks that the newest word survives and that the overrun flag clears after the next accepted transfer. Random frames with jittered low phases and widened gaps between symbols show whether the frame is closed too early or a bit is misread.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    // Event passed from the symbol timer to the word packer.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_BIT  = 2'd1,
        EV_END  = 2'd2
    } pwc_event_e;

endpackage

// File: rtl/pwc_sync.sv
module pwc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.sh   = {q.sh[STAGES-2:0], line_in};
        d.prev = q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sh: '1, prev: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign level = q.sh[STAGES-1];
    assign fall  = q.prev & ~q.sh[STAGES-1];

endmodule

// File: rtl/pwc_timer.sv
module pwc_timer
    import pwc_pkg::*;
#(
    parameter int unsigned SAMPLE_DLY = 250,
    parameter int unsigned IDLE_LIM   = 750
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  logic       fall,
    output pwc_event_e ev,
    output logic       ev_bit,
    output logic       frame_err
);

    localparam int unsigned DLY_W = $clog2(SAMPLE_DLY + 1);
    localparam int unsigned IDL_W = $clog2(IDLE_LIM + 1);
    localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(SAMPLE_DLY - 1);
    localparam logic [IDL_W-1:0] IDL_TOP  = IDL_W'(IDLE_LIM - 1);

    typedef struct packed {
        logic             busy;
        logic [DLY_W-1:0] dly_cnt;
        logic             in_frame;
        logic [IDL_W-1:0] idle_cnt;
        pwc_event_e       ev;
        logic             bit_v;
        logic             err;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d     = q;
        d.ev  = EV_NONE;
        d.err = 1'b0;
        if (fall) begin
            // retrigger: a new edge always restarts the half-symbol delay
            d.err      = q.busy;
            d.busy     = 1'b1;
            d.dly_cnt  = DLY_LOAD;
            d.idle_cnt = '0;
        end else if (q.busy) begin
            if (q.dly_cnt == '0) begin
                d.busy     = 1'b0;
                d.ev       = EV_BIT;
                d.bit_v    = level;
                d.in_frame = 1'b1;
                d.idle_cnt = '0;
            end else begin
                d.dly_cnt = q.dly_cnt - 1'b1;
            end
        end else if (q.in_frame) begin
            if (q.idle_cnt == IDL_TOP) begin
                d.ev       = EV_END;
                d.in_frame = 1'b0;
                d.idle_cnt = '0;
            end else begin
                d.idle_cnt = q.idle_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, dly_cnt: '0, in_frame: 1'b0, idle_cnt: '0,
                   ev: EV_NONE, bit_v: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign ev        = q.ev;
    assign ev_bit    = q.bit_v;
    assign frame_err = q.err;

    // R5: a frame end is never directly preceded by a decoded bit
    assert_end_after_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ev == EV_END) |-> $past(q.ev != EV_BIT));

    // R8: a framing error pulse lasts one cycle
    assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |=> !q.err);

endmodule

// File: rtl/pwc_packer.sv
module pwc_packer
    import pwc_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pwc_event_e        ev,
    input  logic              ev_bit,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic [$clog2(WORD_W+1)-1:0] out_count,
    output logic              out_last,
    output logic              overrun
);

    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [CNT_W-1:0]  n;
        logic              valid;
        logic [WORD_W-1:0] data;
        logic [CNT_W-1:0]  count;
        logic              last;
        logic              ovr;
    } pk_t;

    pk_t q, d;

    logic              emit;
    logic [WORD_W-1:0] e_data;
    logic [CNT_W-1:0]  e_cnt;
    logic              e_last;
    logic [WORD_W-1:0] nacc;
    logic              accepted;

    always_comb begin
        d        = q;
        emit     = 1'b0;
        e_data   = '0;
        e_cnt    = '0;
        e_last   = 1'b0;
        nacc     = q.acc;
        accepted = q.valid & out_ready;
        d.valid  = q.valid & ~out_ready;

        if (ev == EV_BIT) begin
            nacc[LAST_IDX - q.n] = ev_bit;
            if (q.n == LAST_IDX) begin
                emit   = 1'b1;
                e_data = nacc;
                e_cnt  = FULL_CNT;
                d.acc  = '0;
                d.n    = '0;
            end else begin
                d.acc = nacc;
                d.n   = q.n + 1'b1;
            end
        end else if (ev == EV_END) begin
            emit   = 1'b1;
            e_data = q.acc;
            e_cnt  = q.n;
            e_last = 1'b1;
            d.acc  = '0;
            d.n    = '0;
        end

        if (emit) begin
            d.valid = 1'b1;
            d.data  = e_data;
            d.count = e_cnt;
            d.last  = e_last;
            if (q.valid && !out_ready) begin
                d.ovr = 1'b1;
            end else if (accepted) begin
                d.ovr = 1'b0;
            end
        end else if (accepted) begin
            d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{acc: '0, n: '0, valid: 1'b0, data: '0, count: '0,
                   last: 1'b0, ovr: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.valid;
    assign out_data  = q.data;
    assign out_count = q.count;
    assign out_last  = q.last;
    assign overrun   = q.ovr;

    // R6: an offered word is not withdrawn before it is taken
    assert_valid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    // R4: non-final words are always full
    assert_full_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (out_count == FULL_CNT));

    // R5: a final word never carries a full count
    assert_last_partial_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (out_count < FULL_CNT));

    // R7: overrun only rises when a word was left waiting
    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(out_valid && !out_ready));

endmodule

// File: rtl/pwc_rx.sv
module pwc_rx
    import pwc_pkg::*;
#(
    parameter int unsigned WORD_W     = 8,
    parameter int unsigned SAMPLE_DLY = 250,
    parameter int unsigned IDLE_LIM   = 750
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        line_in,
    input  logic                        out_ready,
    output logic                        out_valid,
    output logic [WORD_W-1:0]           out_data,
    output logic [$clog2(WORD_W+1)-1:0] out_count,
    output logic                        out_last,
    output logic                        overrun,
    output logic                        frame_err
);

    logic       level;
    logic       fall;
    pwc_event_e ev;
    logic       ev_bit;

    pwc_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .level   (level),
        .fall    (fall)
    );

    pwc_timer #(.SAMPLE_DLY(SAMPLE_DLY), .IDLE_LIM(IDLE_LIM)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (level),
        .fall      (fall),
        .ev        (ev),
        .ev_bit    (ev_bit),
        .frame_err (frame_err)
    );

    pwc_packer #(.WORD_W(WORD_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .ev_bit    (ev_bit),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_count (out_count),
        .out_last  (out_last),
        .overrun   (overrun)
    );

    // R1: no word or flag may appear in the first cycle after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !overrun && !frame_err));

endmodule

// File: tb/tb_pwc_rx.sv
module tb_pwc_rx;

    localparam int WORD_W = 8;
    localparam int SAMPLE_DLY = 8;
    localparam int IDLE_LIM = 24;
    localparam int SYM = 16;
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b1;
    logic out_ready;
    logic out_valid;
    logic [WORD_W-1:0] out_data;
    logic [CNT_W-1:0] out_count;
    logic out_last;
    logic overrun;
    logic frame_err;

    int ready_mode = 1;   // 0 low, 1 high, 2 random
    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int err_pulses = 0;
    logic [12:0] got[$];
    logic [12:0] exp_q[$];
    logic fbits[64];

    always #4 clk = ~clk;   // 125 MHz

    pwc_rx #(.WORD_W(WORD_W), .SAMPLE_DLY(SAMPLE_DLY), .IDLE_LIM(IDLE_LIM)) dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_count(out_count),
        .out_last(out_last), .overrun(overrun), .frame_err(frame_err)
    );

    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk); #1;
            if (ready_mode == 0) out_ready = 1'b0;
            else if (ready_mode == 1) out_ready = 1'b1;
            else out_ready = ($urandom % 4) != 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) got.push_back({out_last, out_count, out_data});
        if (rst_n && frame_err) err_pulses++;
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        line_in = lvl;
        repeat (n) @(posedge clk);
        #1;
    endtask

    // one symbol; jit shifts the low phase length
    task automatic send_sym(input logic b, input int jit, input int extra_gap);
        int low;
        low = (b ? SYM / 4 : 3 * SYM / 4) + jit;
        hold(1'b0, low);
        hold(1'b1, SYM - low + extra_gap);
    endtask

    // expected words of a frame of n bits from fbits
    function automatic void expect_frame(input int n);
        logic [WORD_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < n; i++) begin
            acc[WORD_W-1-(i % WORD_W)] = fbits[i];
            if ((i % WORD_W) == WORD_W - 1) begin
                exp_q.push_back({1'b0, 4'(WORD_W), acc});
                acc = '0;
            end
        end
        exp_q.push_back({1'b1, 4'(n % WORD_W), acc});
    endfunction

    task automatic send_frame(input int n, input int jit_max, input int extra_gap);
        for (int i = 0; i < n; i++) begin
            int j;
            j = (jit_max == 0) ? 0 : int'($urandom % (2 * jit_max + 1)) - jit_max;
            send_sym(fbits[i], j, extra_gap);
        end
        expect_frame(n);
        hold(1'b1, 60);
    endtask

    task automatic compare(input string req);
        check(got.size() == exp_q.size(), {req, " word count"}, got.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            check(got[i] == exp_q[i], req, got[i], exp_q[i]);
        got.delete();
        exp_q.delete();
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1 valid", out_valid, 0);
        check(overrun == 1'b0, "R1 overrun", overrun, 0);
        check(frame_err == 1'b0, "R1 frame_err", frame_err, 0);
        rst_n = 1'b1;
        hold(1'b1, 50);
        check(got.size() == 0 && out_valid == 1'b0, "R2 idle line", got.size(), 0);

        // R3 R4 R5: exactly one word, 0xA5, ends with empty terminator
        for (int i = 0; i < 8; i++) fbits[i] = (8'hA5 >> (7 - i)) & 1;
        send_frame(8, 0, 0);
        compare("R4 full word A5 and R5 empty last");

        // R5: three bits 1,0,1 left aligned -> 0xA0, count 3
        fbits[0] = 1; fbits[1] = 0; fbits[2] = 1;
        send_frame(3, 0, 0);
        compare("R5 partial 101");

        // R3: all ones then all zeros, 11 bits
        for (int i = 0; i < 11; i++) fbits[i] = (i < 6);
        send_frame(11, 0, 0);
        compare("R3 ones then zeros");

        // R9: widened gaps between symbols keep the frame open
        for (int i = 0; i < 10; i++) fbits[i] = i[0];
        send_frame(10, 2, 10);
        compare("R9 gaps and jitter");

        // R8: glitch edge before sample point, then zero, then one
        hold(1'b0, 2);
        hold(1'b1, 2);
        fbits[0] = 0; fbits[1] = 1;
        send_frame(2, 0, 0);
        check(err_pulses == 1, "R8 frame_err pulses", err_pulses, 1);
        compare("R8 interrupted symbol dropped");

        // R7: stalled consumer, 16 bits -> only terminator survives
        ready_mode = 0;
        hold(1'b1, 2);
        for (int i = 0; i < 16; i++) fbits[i] = 1;
        for (int i = 0; i < 16; i++) send_sym(1'b1, 0, 0);
        hold(1'b1, 60);
        check(overrun == 1'b1, "R7 overrun set", overrun, 1);
        check(out_valid == 1'b1, "R6 word still offered", out_valid, 1);
        check({out_last, out_count, out_data} == 13'h1000, "R7 newest word kept",
              {out_last, out_count, out_data}, 13'h1000);
        ready_mode = 1;
        hold(1'b1, 4);
        check(overrun == 1'b0, "R7 overrun cleared", overrun, 0);
        check(out_valid == 1'b0, "R6 word taken", out_valid, 0);
        got.delete();

        // random frames with random ready and jitter
        ready_mode = 2;
        for (int f = 0; f < 20; f++) begin
            int n;
            n = 1 + int'($urandom % 40);
            for (int i = 0; i < n; i++) fbits[i] = $urandom % 2;
            send_frame(n, 2, int'($urandom % 6));
        end
        ready_mode = 1;
        hold(1'b1, 10);
        compare("R3 R4 R5 R9 random frames");
        check(overrun == 1'b0, "R7 no overrun with live consumer", overrun, 0);
        check(err_pulses == 1, "R8 no spurious frame_err", err_pulses, 1);
        finish_run();
    end

endmodule